// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block collects level-type interrupt requests from up to six attached terminal channels. It also holds two sticky error flags, one for a fail-safe fault and one for a data-discard timeout, and a 16-bit doorbell vector. It combines all of these into a single active-high host interrupt. Software sees one read-only status word and one read/write enable word through a simple register port. Reads are combinational and take effect in the cycle they are presented. Writes and the side effects of a read land on the next rising clock edge.

The channel bits in the status word track the live request levels and do not latch. The error flags and the doorbell bits stay set until software clears them. Any channel whose index lies at or above the installed-channel count is treated as tied low.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the enable word reads 0, both error flags and the doorbell read 0, and `host_irq` is 0.
- R2: Status bits 21..16 show `chan_irq[5..0]` in the same cycle, with channel 1 at bit 16 and channel 6 at bit 21. A bit falls to 0 as soon as its request drops.
- R3: A channel whose index is at or above the installed count reads 0 and cannot interrupt. A count above 6 acts as 6, and a count of 0 masks every channel.
- R4: Status bits 26..24 show the raw `chan_count` value.
- R5: The enable word at 0x804 stores bits 26..16. Every other bit of that word reads 0. Its fields are: per-channel enables in bits 26..21 (channel 6 down to channel 1), the discard enable in bit 20, the fail-safe enable in bit 19, fail-safe auto-clear in bit 18, and the fail-safe mode in bits 17..16.
- R6: A `failsafe_evt` pulse sets status bit 22 from the next cycle onward if the mode field is not 2'b00. It has no effect while the mode field is 2'b00.
- R7: A `discard_evt` pulse sets status bit 23 from the next cycle onward. The bit stays set until a write to 0x800 with data bit 23 set. An event in the same cycle as that write wins.
- R8: Writing 1 to bit 22 at 0x800 clears the fail-safe flag. When auto-clear is 1, a read of 0x800 also clears it. A new event in the same cycle wins over either clear.
- R9: Doorbell bits 15..0 OR in `db_set` on each edge. A read of 0x800 clears them. Bits set in the same cycle as the read survive it.
- R10: `host_irq` is the OR of each unmasked channel AND its enable, the discard flag AND its enable, the fail-safe flag AND its enable, and any doorbell bit. Status bit 31 equals `host_irq`, and bits 30..27 read 0.
- R11: An address other than 0x800 or 0x804 reads 0. Writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (carries the read side effects) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chan_irq | input | 6 | Level interrupt requests, bit 0 = channel 1 |
| failsafe_evt | input | 1 | One-cycle fail-safe fault event |
| discard_evt | input | 1 | One-cycle discard-timeout event |
| db_set | input | 16 | Doorbell bits to set |
| chan_count | input | 3 | Number of installed channels |
| host_irq | output | 1 | Active-high host interrupt |

## Verification
Channel bits, the count field, the enable-driven part of `host_irq` and all read data are due in the same cycle as their inputs. Flag sets, flag clears, doorbell updates and enable writes are due one edge later. The bench therefore drives stimulus just after a falling edge and compares both outputs two nanoseconds later, while the inputs are still steady. Its reference model then advances its own state at the rising edge. Comparing every cycle against that model catches a result that arrives early, late, or is lost to a same-cycle set/clear collision.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h800,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h804
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [5:0]        chan_irq,
  input  logic              failsafe_evt,
  input  logic              discard_evt,
  input  logic [15:0]       db_set,
  input  logic [2:0]        chan_count,
  output logic              host_irq
);
  localparam int NCH    = 6;
  localparam int CTL_LO = 16;
  localparam int CTL_W  = 11;
  localparam int B_FS   = 22;
  localparam int B_DISC = 23;

  logic             st_sel, ct_sel, st_rd, st_wr;
  logic [CTL_W-1:0] ctrl_q;
  logic             fs_q, disc_q;
  logic [15:0]      db_q;
  logic [2:0]       cnt_eff;
  logic [NCH-1:0]   chan_mask, chan_live, chan_en;
  logic             disc_en, fs_en, auto_clr;
  logic [1:0]       fs_mode;

  assign st_sel = reg_addr == STAT_ADDR;
  assign ct_sel = reg_addr == CTRL_ADDR;
  assign st_rd  = reg_rd && st_sel;
  assign st_wr  = reg_wr && st_sel;

  assign chan_en  = ctrl_q[10:5];
  assign disc_en  = ctrl_q[4];
  assign fs_en    = ctrl_q[3];
  assign auto_clr = ctrl_q[2];
  assign fs_mode  = ctrl_q[1:0];

  assign cnt_eff = (chan_count > 3'(NCH)) ? 3'(NCH) : chan_count;

  for (genvar i = 0; i < NCH; i++) begin : g_mask
    assign chan_mask[i] = 3'(i) < cnt_eff;
  end
  assign chan_live = chan_irq & chan_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fs_q   <= 1'b0;
      disc_q <= 1'b0;
      db_q   <= '0;
    end else begin
      if (reg_wr && ct_sel) ctrl_q <= reg_wdata[CTL_LO +: CTL_W];
      fs_q   <= (failsafe_evt && fs_mode != 2'b00) ||
                (fs_q && !(st_wr && reg_wdata[B_FS]) && !(st_rd && auto_clr));
      disc_q <= discard_evt || (disc_q && !(st_wr && reg_wdata[B_DISC]));
      db_q   <= db_set | (st_rd ? 16'h0 : db_q);
    end
  end

  assign host_irq = |(chan_live & chan_en) | (disc_q & disc_en) |
                    (fs_q & fs_en) | (|db_q);

  always_comb begin
    reg_rdata = '0;
    if (st_sel)
      reg_rdata = {host_irq, 4'b0, chan_count, disc_q, fs_q, chan_live, db_q};
    else if (ct_sel)
      reg_rdata = {5'b0, ctrl_q, 16'b0};
  end
endmodule

module irq_status_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fs_evt,
  input logic        disc_evt,
  input logic        st_wr,
  input logic        st_rd,
  input logic        wd22,
  input logic        wd23,
  input logic [1:0]  fs_mode,
  input logic        auto_clr,
  input logic        fs_q,
  input logic        disc_q,
  input logic [15:0] db_set,
  input logic [15:0] db_q,
  input logic        host_irq
);
  assert_fs_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_evt && fs_mode != 2'b00) |=> fs_q);
  assert_fs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_q && !(fs_evt && fs_mode != 2'b00)) |=> !fs_q);
  assert_disc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disc_evt |=> disc_q);
  assert_disc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_q && !(st_wr && wd23)) |=> disc_q);
  assert_fs_autoclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && st_rd && auto_clr && !fs_evt) |=> !fs_q);
  assert_fs_wclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && st_wr && wd22 && !fs_evt) |=> !fs_q);
  assert_db_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && db_set == 16'h0) |=> db_q == 16'h0);
  assert_db_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q != 16'h0) |-> host_irq);
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_evt(failsafe_evt), .disc_evt(discard_evt),
  .st_wr(st_wr), .st_rd(st_rd), .wd22(reg_wdata[22]), .wd23(reg_wdata[23]),
  .fs_mode(fs_mode), .auto_clr(auto_clr), .fs_q(fs_q), .disc_q(disc_q),
  .db_set(db_set), .db_q(db_q), .host_irq(host_irq)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 12'h800;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [5:0]  chan_irq = 0;
  logic        failsafe_evt = 0, discard_evt = 0;
  logic [15:0] db_set = 0;
  logic [2:0]  chan_count = 3'd6;
  logic        host_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] m_ctrl;
  logic        m_fs, m_disc;
  logic [15:0] m_db;

  always #5 clk = ~clk;

  irq_status_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_irq(chan_irq), .failsafe_evt(failsafe_evt), .discard_evt(discard_evt),
    .db_set(db_set), .chan_count(chan_count), .host_irq(host_irq)
  );

  task automatic tick(input string tag);
    int c;
    logic [5:0]  live;
    logic        irq;
    logic [31:0] exp_d;
    #2;
    c = (chan_count > 6) ? 6 : int'(chan_count);
    for (int i = 0; i < 6; i++) live[i] = chan_irq[i] && (i < c);
    irq = (live & m_ctrl[10:5]) != 0 || (m_disc && m_ctrl[4]) ||
          (m_fs && m_ctrl[3]) || m_db != 0;
    if (reg_addr == 12'h800)
      exp_d = {irq, 4'b0, chan_count, m_disc, m_fs, live, m_db};
    else if (reg_addr == 12'h804)
      exp_d = {5'b0, m_ctrl, 16'b0};
    else
      exp_d = 0;
    checks++;
    if (reg_rdata !== exp_d) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", tag, reg_rdata, exp_d);
    end
    checks++;
    if (host_irq !== irq) begin
      errors++;
      $display("FAIL %s host_irq actual %b expected %b", tag, host_irq, irq);
    end
    @(posedge clk);
    if (reg_addr == 12'h800) begin
      if (failsafe_evt && m_ctrl[1:0] != 0) m_fs = 1;
      else if ((reg_wr && reg_wdata[22]) || (reg_rd && m_ctrl[2])) m_fs = 0;
      if (discard_evt) m_disc = 1;
      else if (reg_wr && reg_wdata[23]) m_disc = 0;
      if (reg_rd) m_db = 0;
    end else begin
      if (failsafe_evt && m_ctrl[1:0] != 0) m_fs = 1;
      if (discard_evt) m_disc = 1;
      if (reg_wr && reg_addr == 12'h804) m_ctrl = reg_wdata[26:16];
    end
    m_db = m_db | db_set;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [11:0] a, input string tag);
    reg_addr = a;
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(tag);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    reg_addr = a; reg_rd = 1;
    tick(tag);
    reg_rd = 0;
  endtask

  initial begin
    m_ctrl = 0; m_fs = 0; m_disc = 0; m_db = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle(1, 12'h800, "R1");
    idle(1, 12'h804, "R1");
    wr(12'h804, 32'hFFFF_FFFF, "R5");
    idle(1, 12'h804, "R5");
    wr(12'h804, 32'h07F8_0000, "R5");
    idle(1, 12'h804, "R5");
    chan_irq = 6'b101010; idle(2, 12'h800, "R2");
    chan_irq = 6'b010101; idle(1, 12'h800, "R2");
    chan_irq = 6'b000000; idle(1, 12'h800, "R2");
    chan_irq = 6'b111111;
    chan_count = 3'd3; idle(1, 12'h800, "R3");
    chan_count = 3'd7; idle(1, 12'h800, "R3");
    chan_count = 3'd0; idle(1, 12'h800, "R3");
    chan_count = 3'd5; idle(1, 12'h800, "R4");
    chan_irq = 0; chan_count = 3'd6;
    failsafe_evt = 1; tick("R6"); failsafe_evt = 0;
    idle(2, 12'h800, "R6");
    wr(12'h804, 32'h07F9_0000, "R6");
    failsafe_evt = 1; tick("R6"); failsafe_evt = 0;
    idle(2, 12'h800, "R6");
    rd(12'h800, "R8");
    idle(1, 12'h800, "R8");
    wr(12'h800, 32'h0040_0000, "R8");
    idle(1, 12'h800, "R8");
    wr(12'h804, 32'h07FD_0000, "R8");
    failsafe_evt = 1; tick("R8"); failsafe_evt = 0;
    rd(12'h800, "R8");
    idle(1, 12'h800, "R8");
    failsafe_evt = 1; rd(12'h800, "R8"); failsafe_evt = 0;
    idle(1, 12'h800, "R8");
    wr(12'h800, 32'h0040_0000, "R8");
    discard_evt = 1; tick("R7"); discard_evt = 0;
    idle(3, 12'h800, "R7");
    rd(12'h800, "R7");
    discard_evt = 1; wr(12'h800, 32'h0080_0000, "R7"); discard_evt = 0;
    idle(1, 12'h800, "R7");
    wr(12'h800, 32'h0080_0000, "R7");
    idle(1, 12'h800, "R7");
    wr(12'h804, 32'h0000_0000, "R9");
    db_set = 16'h0001; tick("R9"); db_set = 0;
    db_set = 16'h8000; tick("R9"); db_set = 0;
    idle(1, 12'h800, "R9");
    rd(12'h800, "R9");
    idle(1, 12'h800, "R9");
    db_set = 16'h0010; tick("R9");
    db_set = 16'h0200; rd(12'h800, "R9"); db_set = 0;
    idle(1, 12'h800, "R9");
    rd(12'h800, "R9");
    chan_irq = 6'b000100; idle(1, 12'h800, "R10");
    wr(12'h804, 32'h0080_0000, "R10");
    idle(1, 12'h800, "R10");
    wr(12'h804, 32'h0000_0000, "R10");
    discard_evt = 1; tick("R10"); discard_evt = 0;
    idle(1, 12'h800, "R10");
    wr(12'h804, 32'h0010_0000, "R10");
    idle(1, 12'h800, "R10");
    chan_irq = 0;
    idle(1, 12'h808, "R11");
    wr(12'h808, 32'hFFFF_FFFF, "R11");
    idle(1, 12'h804, "R11");
    idle(1, 12'h800, "R11");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule